// File: doc/BRIEF.md
# Virtual-Channel Crossbar Command Router

This block is the command crossbar of a node's system interconnect. Five sources feed it 64-bit command/address words: the system request queue fed by the processor cores (input 0), three point-to-point link receivers (inputs 1 to 3) and the memory controller (input 4). Each word is sorted by its command kind into one of four virtual channels: request, posted, probe or response. It is then held in its source's command buffer, which is split into one partition per channel with a parameterised entry count.

Five outputs drain the buffers: three link transmitters (outputs 0 to 2), the memory command queue (output 3) and the core side (output 4). Every output uses valid/ready flow control. Each output serves the highest-priority channel that has work for it, and rotates between sources within that channel. A probe is copied to every output in its destination mask. It keeps its buffer entry until the last copy has been taken. Cache-line data is not moved here. A command that carries data waits until a per-source, per-channel data-valid input says that its line is present.

Top module: `vc_xbar_router`

## Requirements
- R1: After reset, no output presents a valid packet.
- R2: Command kind is taken from bits [2:0] of the word: 0 read, 1 non-posted write and 2 cache-block command go to the request channel (code 0); 3 posted write goes to the posted channel (code 1); 4 probe goes to the probe channel (code 2); 5 read response, 6 probe response and 7 completion go to the response channel (code 3). The code appears on the output's channel field.
- R3: A non-probe packet is delivered only to the lowest-numbered output set in its destination mask.
- R4: A probe is presented on every output in its destination mask. Its entry stays occupied, and later probes from that source wait, until every one of those outputs has accepted a copy.
- R5: A packet is accepted only when its channel's partition at that input has a free entry. A full partition does not block other channels of the same input. Default partitions (request, posted, probe, response) are 3/2/2/3 for input 0, 5/3/3/5 for each link input and 4/2/2/4 for input 4.
- R6: A packet with an all-zero destination mask is refused.
- R7: At each output, a pending response beats a probe, a probe beats a posted packet and a posted packet beats a request.
- R8: Within the winning channel, each output grants sources round-robin, starting after the source it last served.
- R9: A non-probe packet whose data flag is set is not presented until the data-valid input for its source and channel is high, and it leaves with its data flag set.
- R10: A probe never leaves with its data flag set, and it does not wait for data-valid.
- R11: Packets of one channel from one input to one output leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_vld_i | input | NUM_IN | Per-input packet valid |
| in_rdy_o | output | NUM_IN | Per-input accept, depends on the offered packet's channel |
| in_cmd_i | input | NUM_IN x 64 | Command/address words, kind in bits [2:0] |
| in_dst_i | input | NUM_IN x NUM_OUT | Destination output masks |
| in_dat_i | input | NUM_IN | Packet has an associated data line |
| data_vld_i | input | NUM_IN x 4 | Data line present for the head packet of each source channel |
| out_vld_o | output | NUM_OUT | Per-output packet valid |
| out_rdy_i | input | NUM_OUT | Per-output accept |
| out_cmd_o | output | NUM_OUT x 64 | Forwarded command words |
| out_vc_o | output | NUM_OUT x 2 | Channel code of the forwarded packet |
| out_src_o | output | NUM_OUT x 3 | Source input of the forwarded packet |
| out_dat_o | output | NUM_OUT | Forwarded packet carries data |

## Verification
The assertions watch on every cycle that no partition holds more entries than its limit. They also check that an empty-mask packet is never accepted, that no output presents a channel while a higher channel has work for it, that data-carrying packets appear only with their data-valid high, and that probes never carry data. Several behaviours show only over a sequence of cycles, so the bench's scenarios must show them. These are the mapping of kinds to channels, lowest-output selection, probe entry retention across partial acceptance, the exact round-robin order and arrival order per channel.

// File: rtl/vcx_pkg.sv
package vcx_pkg;
  localparam int unsigned NUM_VC = 4;
  localparam int unsigned VC_W   = 2;
  localparam int unsigned CMD_W  = 64;
  localparam int unsigned KIND_W = 3;

  typedef enum logic [VC_W-1:0] {
    VC_REQ   = 2'd0,
    VC_POST  = 2'd1,
    VC_PROBE = 2'd2,
    VC_RESP  = 2'd3
  } vc_e;

  function automatic vc_e vc_of(input logic [KIND_W-1:0] kind);
    case (kind)
      3'd3:                vc_of = VC_POST;
      3'd4:                vc_of = VC_PROBE;
      3'd5, 3'd6, 3'd7:    vc_of = VC_RESP;
      default:             vc_of = VC_REQ;
    endcase
  endfunction
endpackage

// File: rtl/vcx_cmd_fifo.sv
module vcx_cmd_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic         vld_o,
  output logic [W-1:0] rdata_o,
  output logic [7:0]   cnt_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [7:0]    cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    bump = (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= bump(wp_q);
      if (pop_i)  rp_q <= bump(rp_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 8'd1;
        2'b01:   cnt_q <= cnt_q - 8'd1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  assign vld_o   = (cnt_q != 8'd0);
  assign rdata_o = mem_q[rp_q];
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/vcx_in_port.sv
module vcx_in_port import vcx_pkg::*; #(
  parameter int unsigned NUM_OUT = 5,
  parameter logic [NUM_VC-1:0][7:0] LIM = {8'd5, 8'd3, 8'd3, 8'd5}
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            vld_i,
  output logic                            rdy_o,
  input  logic [CMD_W-1:0]                cmd_i,
  input  logic [NUM_OUT-1:0]              dst_i,
  input  logic                            dat_i,
  input  logic [NUM_VC-1:0]               data_vld_i,
  input  logic [NUM_VC-1:0][NUM_OUT-1:0]  fire_i,
  output logic [NUM_VC-1:0][NUM_OUT-1:0]  req_o,
  output logic [NUM_VC-1:0][CMD_W-1:0]    hd_cmd_o,
  output logic [NUM_VC-1:0]               hd_dat_o,
  output logic [NUM_VC-1:0][7:0]          occ_o
);
  localparam int unsigned EW = CMD_W + NUM_OUT + 1;

  vc_e              in_vc;
  logic [NUM_OUT-1:0] dst_n;
  logic             dat_n;

  always_comb begin
    in_vc = vc_of(cmd_i[KIND_W-1:0]);
    dst_n = (in_vc == VC_PROBE) ? dst_i : (dst_i & (~dst_i + 1'b1));
    dat_n = dat_i && (in_vc != VC_PROBE);
    rdy_o = (|dst_i) && (occ_o[in_vc] < LIM[in_vc]);
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic               push, pop, hd_vld;
    logic [EW-1:0]      hd;
    logic [NUM_OUT-1:0] hd_dst, sent_q, left;
    logic               hd_dat;

    assign push = vld_i && rdy_o && (in_vc == vc_e'(v));

    vcx_cmd_fifo #(.W(EW), .DEPTH(int'(LIM[v]))) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push),
      .wdata_i ({dat_n, dst_n, cmd_i}),
      .pop_i   (pop),
      .vld_o   (hd_vld),
      .rdata_o (hd),
      .cnt_o   (occ_o[v])
    );

    assign hd_dst = hd[CMD_W +: NUM_OUT];
    assign hd_dat = hd[EW-1];
    assign left   = hd_dst & ~(sent_q | fire_i[v]);
    assign pop    = hd_vld && (|fire_i[v]) && (left == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          sent_q <= '0;
      else if (pop)         sent_q <= '0;
      else if (|fire_i[v])  sent_q <= sent_q | fire_i[v];
    end

    always_comb begin
      req_o[v] = '0;
      if (hd_vld && ((v == int'(VC_PROBE)) || !hd_dat || data_vld_i[v]))
        req_o[v] = hd_dst & ~sent_q;
    end

    assign hd_cmd_o[v] = hd[CMD_W-1:0];
    assign hd_dat_o[v] = hd_dat;
  end
endmodule

// File: rtl/vcx_out_arb.sv
module vcx_out_arb import vcx_pkg::*; #(
  parameter int unsigned NUM_IN = 5,
  parameter int unsigned SRC_W  = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_IN-1:0][NUM_VC-1:0] req_i,
  input  logic                          rdy_i,
  output logic                          vld_o,
  output logic [SRC_W-1:0]              sel_in_o,
  output logic [VC_W-1:0]               sel_vc_o,
  output logic                          fire_o
);
  logic [SRC_W-1:0]  ptr_q;
  logic [NUM_IN-1:0] cand;
  logic              found;

  always_comb begin
    sel_vc_o = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      for (int i = 0; i < NUM_IN; i++) begin
        if (req_i[i][v]) sel_vc_o = VC_W'(v);
      end
    end
    for (int i = 0; i < NUM_IN; i++) cand[i] = req_i[i][sel_vc_o];
    found    = 1'b0;
    sel_in_o = '0;
    for (int k = 0; k < NUM_IN; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % NUM_IN;
      if (!found && cand[idx]) begin
        found    = 1'b1;
        sel_in_o = SRC_W'(idx);
      end
    end
    vld_o  = found;
    fire_o = found && rdy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (fire_o) ptr_q <= (sel_in_o == SRC_W'(NUM_IN-1)) ? '0 : sel_in_o + 1'b1;
  end
endmodule

// File: rtl/vc_xbar_router.sv
module vc_xbar_router import vcx_pkg::*; #(
  parameter int unsigned NUM_IN  = 5,
  parameter int unsigned NUM_OUT = 5,
  parameter logic [NUM_IN-1:0][NUM_VC-1:0][7:0] VC_LIMIT = {
    32'h04_02_02_04, 32'h05_03_03_05, 32'h05_03_03_05,
    32'h05_03_03_05, 32'h03_02_02_03},
  localparam int unsigned SRC_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_IN-1:0]                 in_vld_i,
  output logic [NUM_IN-1:0]                 in_rdy_o,
  input  logic [NUM_IN-1:0][CMD_W-1:0]      in_cmd_i,
  input  logic [NUM_IN-1:0][NUM_OUT-1:0]    in_dst_i,
  input  logic [NUM_IN-1:0]                 in_dat_i,
  input  logic [NUM_IN-1:0][NUM_VC-1:0]     data_vld_i,
  output logic [NUM_OUT-1:0]                out_vld_o,
  input  logic [NUM_OUT-1:0]                out_rdy_i,
  output logic [NUM_OUT-1:0][CMD_W-1:0]     out_cmd_o,
  output logic [NUM_OUT-1:0][VC_W-1:0]      out_vc_o,
  output logic [NUM_OUT-1:0][SRC_W-1:0]     out_src_o,
  output logic [NUM_OUT-1:0]                out_dat_o
);
  logic [NUM_IN-1:0][NUM_VC-1:0][NUM_OUT-1:0] req_ivo, fire_ivo;
  logic [NUM_OUT-1:0][NUM_IN-1:0][NUM_VC-1:0] req_oiv;
  logic [NUM_IN-1:0][NUM_VC-1:0][CMD_W-1:0]   hd_cmd;
  logic [NUM_IN-1:0][NUM_VC-1:0]              hd_dat;
  logic [NUM_IN-1:0][NUM_VC-1:0][7:0]         occ;
  logic [NUM_OUT-1:0]                         arb_fire;
  logic [NUM_OUT-1:0][SRC_W-1:0]              sel_in;
  logic [NUM_OUT-1:0][VC_W-1:0]               sel_vc;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    vcx_in_port #(.NUM_OUT(NUM_OUT), .LIM(VC_LIMIT[i])) u_in (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .vld_i      (in_vld_i[i]),
      .rdy_o      (in_rdy_o[i]),
      .cmd_i      (in_cmd_i[i]),
      .dst_i      (in_dst_i[i]),
      .dat_i      (in_dat_i[i]),
      .data_vld_i (data_vld_i[i]),
      .fire_i     (fire_ivo[i]),
      .req_o      (req_ivo[i]),
      .hd_cmd_o   (hd_cmd[i]),
      .hd_dat_o   (hd_dat[i]),
      .occ_o      (occ[i])
    );
  end

  always_comb begin
    for (int o = 0; o < NUM_OUT; o++)
      for (int i = 0; i < NUM_IN; i++)
        for (int v = 0; v < NUM_VC; v++) begin
          req_oiv[o][i][v]  = req_ivo[i][v][o];
          fire_ivo[i][v][o] = arb_fire[o] && (sel_in[o] == SRC_W'(i))
                              && (sel_vc[o] == VC_W'(v));
        end
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    vcx_out_arb #(.NUM_IN(NUM_IN), .SRC_W(SRC_W)) u_arb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (req_oiv[o]),
      .rdy_i    (out_rdy_i[o]),
      .vld_o    (out_vld_o[o]),
      .sel_in_o (sel_in[o]),
      .sel_vc_o (sel_vc[o]),
      .fire_o   (arb_fire[o])
    );
    assign out_cmd_o[o] = hd_cmd[sel_in[o]][sel_vc[o]];
    assign out_dat_o[o] = out_vld_o[o] && hd_dat[sel_in[o]][sel_vc[o]];
    assign out_vc_o[o]  = sel_vc[o];
    assign out_src_o[o] = sel_in[o];
  end
endmodule

// File: rtl/vc_xbar_router_chk.sv
module vc_xbar_router_chk import vcx_pkg::*; #(
  parameter int unsigned NUM_IN  = 5,
  parameter int unsigned NUM_OUT = 5,
  parameter logic [NUM_IN-1:0][NUM_VC-1:0][7:0] VC_LIMIT = '0,
  localparam int unsigned SRC_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input logic                                      clk_i,
  input logic                                      rst_ni,
  input logic [NUM_IN-1:0]                         in_rdy_o,
  input logic [NUM_IN-1:0][NUM_OUT-1:0]            in_dst_i,
  input logic [NUM_IN-1:0][NUM_VC-1:0]             data_vld_i,
  input logic [NUM_OUT-1:0]                        out_vld_o,
  input logic [NUM_OUT-1:0][VC_W-1:0]              out_vc_o,
  input logic [NUM_OUT-1:0][SRC_W-1:0]             out_src_o,
  input logic [NUM_OUT-1:0]                        out_dat_o,
  input logic [NUM_OUT-1:0][NUM_IN-1:0][NUM_VC-1:0] req_oiv,
  input logic [NUM_IN-1:0][NUM_VC-1:0][7:0]        occ
);
  logic [NUM_OUT-1:0] hi_req;

  always_comb begin
    for (int o = 0; o < NUM_OUT; o++) begin
      hi_req[o] = 1'b0;
      for (int i = 0; i < NUM_IN; i++)
        for (int v = 0; v < NUM_VC; v++)
          if (req_oiv[o][i][v] && (VC_W'(v) > out_vc_o[o])) hi_req[o] = 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_ai
    for (genvar v = 0; v < NUM_VC; v++) begin : g_av
      AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        occ[i][v] <= VC_LIMIT[i][v]); // R5
    end
    AST_EMPTY_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_dst_i[i] == '0) |-> !in_rdy_o[i]); // R6
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_ao
    AST_VC_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_vld_o[o] |-> !hi_req[o]); // R7
    AST_DATA_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_vld_o[o] && out_dat_o[o]) |-> data_vld_i[out_src_o[o]][out_vc_o[o]]); // R9
    AST_PROBE_NODATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_vld_o[o] && (out_vc_o[o] == VC_PROBE)) |-> !out_dat_o[o]); // R10
  end
endmodule

bind vc_xbar_router vc_xbar_router_chk #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .VC_LIMIT(VC_LIMIT)
) u_chk (.*);

// File: tb/vc_xbar_router_tb.sv
module vc_xbar_router_tb;
  import vcx_pkg::*;
  localparam int NI = 5;
  localparam int NO = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0]           in_vld = '0;
  logic [NI-1:0]           in_rdy;
  logic [NI-1:0][63:0]     in_cmd = '0;
  logic [NI-1:0][NO-1:0]   in_dst = '0;
  logic [NI-1:0]           in_dat = '0;
  logic [NI-1:0][3:0]      data_vld = '0;
  logic [NO-1:0]           out_vld;
  logic [NO-1:0]           out_rdy = '0;
  logic [NO-1:0][63:0]     out_cmd;
  logic [NO-1:0][1:0]      out_vc;
  logic [NO-1:0][2:0]      out_src;
  logic [NO-1:0]           out_dat;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  vc_xbar_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_vld_i(in_vld), .in_rdy_o(in_rdy),
    .in_cmd_i(in_cmd), .in_dst_i(in_dst), .in_dat_i(in_dat),
    .data_vld_i(data_vld), .out_vld_o(out_vld), .out_rdy_i(out_rdy),
    .out_cmd_o(out_cmd), .out_vc_o(out_vc), .out_src_o(out_src),
    .out_dat_o(out_dat)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [60:0] tag, input logic [2:0] kind);
    mk = {tag, kind};
  endfunction

  task automatic do_reset();
    in_vld = '0; out_rdy = '0; data_vld = '0; in_dat = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input int i, input logic [63:0] cmd, input logic [NO-1:0] dst,
                      input bit dat);
    @(negedge clk);
    in_vld[i] = 1'b1; in_cmd[i] = cmd; in_dst[i] = dst; in_dat[i] = dat;
    #1;
    check(in_rdy[i], "R5", "accept on free partition", 64'(in_rdy[i]), 64'd1);
    @(posedge clk); #1;
    in_vld[i] = 1'b0; in_dat[i] = 1'b0;
  endtask

  task automatic peek_rdy(input int i, input logic [63:0] cmd, input logic [NO-1:0] dst,
                          output bit r);
    @(negedge clk);
    in_vld[i] = 1'b1; in_cmd[i] = cmd; in_dst[i] = dst;
    #1 r = in_rdy[i];
    in_vld[i] = 1'b0;
  endtask

  // check head at output o, then let it go for one cycle
  task automatic take(input int o, input logic [1:0] vc, input int src,
                      input logic [63:0] cmd, input string req);
    @(negedge clk);
    check(out_vld[o], req, "out valid", 64'(out_vld[o]), 64'd1);
    check(out_vc[o] == vc, req, "out channel", 64'(out_vc[o]), 64'(vc));
    check(out_src[o] == 3'(src), req, "out source", 64'(out_src[o]), 64'(src));
    check(out_cmd[o] == cmd, req, "out command", out_cmd[o], cmd);
    out_rdy[o] = 1'b1;
    @(negedge clk);
    out_rdy[o] = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check(out_vld == '0, "R1", "no valid after reset", 64'(out_vld), 64'd0);
  endtask

  task automatic t_classify();
    logic [1:0] exp_vc [8] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd3};
    do_reset();
    for (int k = 0; k < 8; k++) begin
      send(1, mk(61'(100 + k), 3'(k)), 5'b00001, 1'b0);
      take(0, exp_vc[k], 1, mk(61'(100 + k), 3'(k)), "R2");
    end
  endtask

  task automatic t_lowest();
    do_reset();
    send(2, mk(61'h55, 3'd5), 5'b11010, 1'b0);
    @(negedge clk);
    check(out_vld == 5'b00010, "R3", "only lowest output", 64'(out_vld), 64'b00010);
    take(1, 2'd3, 2, mk(61'h55, 3'd5), "R3");
    @(negedge clk);
    check(out_vld == '0, "R3", "nothing left", 64'(out_vld), 64'd0);
  endtask

  task automatic t_probe();
    bit r;
    do_reset();
    for (int k = 0; k < 3; k++) send(1, mk(61'(200 + k), 3'd4), 5'b10110, 1'b0);
    peek_rdy(1, mk(61'h0, 3'd4), 5'b10110, r);
    check(!r, "R5", "probe partition full", 64'(r), 64'd0);
    @(negedge clk);
    check(out_vld == 5'b10110, "R4", "probe on all targets", 64'(out_vld), 64'b10110);
    check(out_cmd[4] == mk(61'd200, 3'd4), "R4", "copy on out4", out_cmd[4], mk(61'd200, 3'd4));
    out_rdy = 5'b00110;
    @(negedge clk);
    out_rdy = '0;
    check(out_vld == 5'b10000, "R4", "partial accept holds entry", 64'(out_vld), 64'b10000);
    peek_rdy(1, mk(61'h0, 3'd4), 5'b10110, r);
    check(!r, "R4", "entry still held", 64'(r), 64'd0);
    out_rdy = 5'b10000;
    @(negedge clk);
    out_rdy = '0;
    check(out_vld == 5'b10110, "R4", "next probe after full accept", 64'(out_vld), 64'b10110);
    check(out_cmd[1] == mk(61'd201, 3'd4), "R11", "probe order", out_cmd[1], mk(61'd201, 3'd4));
    peek_rdy(1, mk(61'h0, 3'd4), 5'b10110, r);
    check(r, "R4", "entry freed", 64'(r), 64'd1);
  endtask

  task automatic t_partition();
    bit r;
    do_reset();
    for (int k = 0; k < 3; k++) send(0, mk(61'(k), 3'd0), 5'b00001, 1'b0);
    peek_rdy(0, mk(61'h9, 3'd0), 5'b00001, r);
    check(!r, "R5", "request partition full", 64'(r), 64'd0);
    peek_rdy(0, mk(61'h9, 3'd3), 5'b00001, r);
    check(r, "R5", "posted still accepted", 64'(r), 64'd1);
    peek_rdy(0, mk(61'h9, 3'd3), 5'b00000, r);
    check(!r, "R6", "empty mask refused", 64'(r), 64'd0);
  endtask

  task automatic t_priority();
    do_reset();
    send(1, mk(61'h10, 3'd0), 5'b00001, 1'b0);
    send(1, mk(61'h11, 3'd3), 5'b00001, 1'b0);
    send(1, mk(61'h12, 3'd4), 5'b00001, 1'b0);
    send(1, mk(61'h13, 3'd7), 5'b00001, 1'b0);
    take(0, 2'd3, 1, mk(61'h13, 3'd7), "R7");
    take(0, 2'd2, 1, mk(61'h12, 3'd4), "R7");
    take(0, 2'd1, 1, mk(61'h11, 3'd3), "R7");
    take(0, 2'd0, 1, mk(61'h10, 3'd0), "R7");
  endtask

  task automatic t_round_robin();
    do_reset();
    for (int i = 1; i <= 3; i++)
      for (int k = 0; k < 2; k++) send(i, mk(61'(i * 16 + k), 3'd1), 5'b01000, 1'b0);
    for (int k = 0; k < 2; k++)
      for (int i = 1; i <= 3; i++) take(3, 2'd0, i, mk(61'(i * 16 + k), 3'd1), "R8 R11");
  endtask

  task automatic t_data();
    do_reset();
    send(2, mk(61'h77, 3'd0), 5'b00010, 1'b1);
    @(negedge clk);
    check(!out_vld[1], "R9", "held without data", 64'(out_vld[1]), 64'd0);
    data_vld[2][0] = 1'b1;
    #1;
    check(out_vld[1] && out_dat[1], "R9", "released with data", 64'({out_vld[1], out_dat[1]}), 64'b11);
    take(1, 2'd0, 2, mk(61'h77, 3'd0), "R9");
    data_vld = '0;
    send(3, mk(61'h78, 3'd4), 5'b00100, 1'b1);
    @(negedge clk);
    check(out_vld[2], "R10", "probe ignores data valid", 64'(out_vld[2]), 64'd1);
    check(!out_dat[2], "R10", "probe carries no data", 64'(out_dat[2]), 64'd0);
  endtask

  initial begin
    t_reset();
    t_classify();
    t_lowest();
    t_probe();
    t_partition();
    t_priority();
    t_round_robin();
    t_data();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule